// File: doc/BRIEF.md
# Flash Read Accelerator Cache

This block sits between a processor and a slow flash array whose reads return a whole 256-bit line. It has two request ports. The instruction port has a 32-line cache. The data port has an 8-line cache. Each port answers reads from three places, checked in this order: the line most recently returned by flash (the current buffer), a line loaded from outside (the prefetch buffer) and a fully associative cache array. When all three miss, the port asks flash for the whole line. It then stores that line in the current buffer and, when the request may allocate, in the cache array. Replacement takes free entries first and then the least recently used entry.

Only one flash line read is in flight at any time. A shared arbiter serves a pending data-port miss before a pending instruction-port miss. The flash is a fixed-latency responder: it takes a line address and later returns the line for one cycle.

The `mode_wide` input sets how a line is split into words: four 64-bit words or two 128-bit words. There is one cache-enable input per port and one flush input that acts on both ports. A small address region is treated as non-cacheable, and data-port requests marked as DMA do not use the cache array.

Top module: `flash_read_accel`

## Requirements
- R1: Addresses are byte addresses, and a line's address is `addr[ADDR_W-1:5]`. With `mode_wide`=0 the returned word is the 64-bit slice `addr[4:3]` of the line (bits `64*k +: 64`), placed in the low half of the 128-bit data with the high half zero. With `mode_wide`=1 the returned word is the 128-bit slice `addr[4]` (bits `128*k +: 128`).
- R2: A hit in the cache array raises ready and response-valid in the same cycle as the request, and starts no flash read.
- R3: A miss happens only when the line is in none of the current buffer, the prefetch buffer and the cache array. A miss issues exactly one flash line read for that line address. No flash read is issued while no request is pending, and nothing is valid after reset.
- R4: A fill goes to the lowest-numbered free entry. When every entry is valid, the fill replaces the least recently used entry. Array hits and fills both make the touched entry the most recently used. A line address is held in at most one entry.
- R5: A request whose line is in the current buffer is answered at once and starts no flash read.
- R6: When a port's enable input is 0, its cache array is neither searched nor written. The current and prefetch buffers still answer.
- R7: Addresses whose top four bits equal `NC_TAG` (default 4'hF) always cause a flash read. Such a line is never written to the array or to the current buffer.
- R8: A data-port request with `d_req_dma`=1 does not search the cache array and does not allocate into it. A CPU request has `d_req_dma`=0.
- R9: If both ports have a line read waiting while flash is idle, the data port's read is issued first.
- R10: A one-cycle `flush` pulse clears every valid bit of both arrays, both current buffers and both prefetch buffers. It also returns the age order so that entry 0 is youngest.
- R11: While a port's line read is outstanding, that port holds ready low. In the cycle the line returns, the port answers the waiting request from the returning line.
- R12: `i_pf_load` writes `i_pf_line`/`i_pf_data` into the instruction prefetch buffer. A later request that hits this buffer starts no flash read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_wide | input | 1 | 0: 4 x 64-bit words per line, 1: 2 x 128-bit words |
| i_en | input | 1 | Instruction cache array enable |
| d_en | input | 1 | Data cache array enable |
| flush | input | 1 | Invalidate both caches and all buffers |
| i_req_valid | input | 1 | Instruction request valid |
| i_req_addr | input | ADDR_W | Instruction byte address |
| i_req_ready | output | 1 | Instruction request accepted |
| i_resp_valid | output | 1 | Instruction data valid |
| i_resp_data | output | 128 | Instruction data |
| i_pf_load | input | 1 | Load the prefetch buffer |
| i_pf_line | input | ADDR_W-5 | Prefetch line address |
| i_pf_data | input | 256 | Prefetch line contents |
| d_req_valid | input | 1 | Data request valid |
| d_req_addr | input | ADDR_W | Data byte address |
| d_req_dma | input | 1 | 1: request from DMA, 0: from CPU |
| d_req_ready | output | 1 | Data request accepted |
| d_resp_valid | output | 1 | Data valid |
| d_resp_data | output | 128 | Data |
| fl_req_valid | output | 1 | Flash line read issued |
| fl_req_line | output | ADDR_W-5 | Flash line address |
| fl_rsp_valid | input | 1 | Flash line returned |
| fl_rsp_data | input | 256 | Flash line contents |

## Verification
Some properties are checked on every cycle by assertions. A held request stays stalled until its fill returns. A current-buffer hit never leads to a line read. A flush empties the valid bits on the next cycle. A non-cacheable fill leaves the array untouched. The line address held in the cache is never duplicated. The data port wins when both ports want flash at once. A touched entry becomes youngest. Other behaviours need a sequence of requests, so only the bench scenarios show them. These are the order of victims across a series of evictions, the absence of allocation for DMA and while a port is disabled, prefetch-buffer hits, and the word chosen in each mode. The bench checks them by comparing returned data and by counting flash reads.

// File: rtl/fra_pkg.sv
package fra_pkg;
  localparam int LINE_W = 256;
  localparam int WORD_W = 128;
  localparam int OFS_W  = 5;
  localparam int NC_W   = 4;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2
  } fra_state_e;

  function automatic logic [WORD_W-1:0] pick_word(
    input logic [LINE_W-1:0] line,
    input logic [1:0]        off,
    input logic              wide
  );
    logic [WORD_W-1:0] w;
    if (wide) w = line[off[1]*128 +: 128];
    else      w = {64'b0, line[off*64 +: 64]};
    return w;
  endfunction
endpackage

// File: rtl/fra_lru.sv
module fra_lru
  import fra_pkg::*;
#(
  parameter int LINES = 8,
  localparam int IW = $clog2(LINES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          touch_en,
  input  logic [IW-1:0] touch_idx,
  output logic [IW-1:0] oldest_idx
);
  logic [IW-1:0] age_q [LINES];
  logic [IW-1:0] age_n [LINES];
  logic          age_ce;

  // next-state: touched entry becomes 0, younger ones age by one
  always_comb begin
    age_ce = flush | touch_en;
    for (int i = 0; i < LINES; i++) begin
      age_n[i] = age_q[i];
      if (flush) age_n[i] = IW'(i);
      else if (touch_en) begin
        if (IW'(i) == touch_idx)             age_n[i] = '0;
        else if (age_q[i] < age_q[touch_idx]) age_n[i] = age_q[i] + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < LINES; i++) age_q[i] <= IW'(i);
    end else if (age_ce) begin
      for (int i = 0; i < LINES; i++) age_q[i] <= age_n[i];
    end
  end

  always_comb begin
    oldest_idx = '0;
    for (int i = 0; i < LINES; i++)
      if (age_q[i] == IW'(LINES-1)) oldest_idx = IW'(i);
  end

  AST_TOUCH_YOUNGEST: assert property (@(posedge clk) disable iff (!rst_n)
    (touch_en && !flush) |=> (age_q[$past(touch_idx)] == '0)); // R4
endmodule

// File: rtl/fra_port.sv
module fra_port
  import fra_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int LINES  = 8,
  parameter logic [NC_W-1:0] NC_TAG = 4'hF,
  localparam int LA_W = ADDR_W - OFS_W,
  localparam int IW   = $clog2(LINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              wide,
  input  logic              flush,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_dma,
  output logic              req_ready,
  output logic              resp_valid,
  output logic [WORD_W-1:0] resp_data,
  input  logic              pf_load,
  input  logic [LA_W-1:0]   pf_line,
  input  logic [LINE_W-1:0] pf_data,
  output logic              line_req,
  output logic [LA_W-1:0]   line_addr,
  input  logic              grant,
  input  logic              fill_valid,
  input  logic [LINE_W-1:0] fill_data
);
  // request decode
  logic [LA_W-1:0] la;
  logic            nc;
  logic            use_arr;
  logic [2:0]      addr_unused;
  assign la          = req_addr[ADDR_W-1:OFS_W];
  assign nc          = (req_addr[ADDR_W-1 -: NC_W] == NC_TAG);
  assign use_arr     = en && !req_dma && !nc;
  assign addr_unused = req_addr[2:0];

  // state
  fra_state_e       st_q, st_n;
  logic [LA_W-1:0]  mla_q, mla_n;
  logic             malloc_q, malloc_n;
  logic             mnc_q, mnc_n;
  logic             cur_v_q, cur_v_n;
  logic [LA_W-1:0]  cur_la_q;
  logic [LINE_W-1:0] cur_d_q;
  logic             pf_v_q, pf_v_n;
  logic [LA_W-1:0]  pf_la_q;
  logic [LINE_W-1:0] pf_d_q;
  logic [LINES-1:0] vld_q, vld_n;
  logic [LA_W-1:0]  tag_q [LINES];
  logic [LINE_W-1:0] dat_q [LINES];

  // lookup
  logic [LINES-1:0] hit_vec;
  logic [IW-1:0]    hit_idx;
  logic             cur_hit, pf_hit, arr_hit, lookup_hit;
  logic [LINE_W-1:0] src_line, resp_line;

  for (genvar g = 0; g < LINES; g++) begin : g_cmp
    assign hit_vec[g] = vld_q[g] && (tag_q[g] == la);
  end

  assign cur_hit    = cur_v_q && (cur_la_q == la) && !nc;
  assign pf_hit     = pf_v_q && (pf_la_q == la) && !nc;
  assign arr_hit    = use_arr && (|hit_vec);
  assign lookup_hit = cur_hit || pf_hit || arr_hit;

  always_comb begin
    hit_idx = '0;
    for (int i = 0; i < LINES; i++)
      if (hit_vec[i]) hit_idx = IW'(i);
  end

  always_comb begin
    if (cur_hit)     src_line = cur_d_q;
    else if (pf_hit) src_line = pf_d_q;
    else             src_line = dat_q[hit_idx];
  end

  // victim choice: lowest free entry, else oldest
  logic [IW-1:0] free_idx, oldest_idx, victim;
  logic          any_free;
  always_comb begin
    free_idx = '0;
    any_free = 1'b0;
    for (int i = LINES-1; i >= 0; i--) begin
      if (!vld_q[i]) begin
        free_idx = IW'(i);
        any_free = 1'b1;
      end
    end
    victim = any_free ? free_idx : oldest_idx;
  end

  // control next-state
  logic          fill_take, alloc_we, cur_we, touch_en;
  logic [IW-1:0] touch_idx;

  always_comb begin
    st_n      = st_q;
    mla_n     = mla_q;
    malloc_n  = malloc_q;
    mnc_n     = mnc_q;
    req_ready = 1'b0;
    line_req  = 1'b0;
    fill_take = 1'b0;
    touch_en  = 1'b0;
    touch_idx = hit_idx;
    unique case (st_q)
      ST_IDLE: begin
        if (req_valid) begin
          if (lookup_hit) begin
            req_ready = 1'b1;
            if (!cur_hit && !pf_hit) touch_en = 1'b1;
          end else begin
            st_n     = ST_REQ;
            mla_n    = la;
            malloc_n = use_arr;
            mnc_n    = nc;
          end
        end
      end
      ST_REQ: begin
        line_req = 1'b1;
        if (grant) st_n = ST_WAIT;
      end
      ST_WAIT: begin
        if (fill_valid) begin
          req_ready = 1'b1;
          fill_take = 1'b1;
          st_n      = ST_IDLE;
        end
      end
      default: st_n = ST_IDLE;
    endcase
    alloc_we = fill_take && malloc_q && !flush;
    cur_we   = fill_take && !mnc_q;
    if (alloc_we) begin
      touch_en  = 1'b1;
      touch_idx = victim;
    end
  end

  always_comb begin
    cur_v_n = cur_v_q;
    if (flush)       cur_v_n = 1'b0;
    else if (cur_we) cur_v_n = 1'b1;
    pf_v_n = pf_v_q;
    if (pf_load)    pf_v_n = 1'b1;
    else if (flush) pf_v_n = 1'b0;
    vld_n = vld_q;
    if (flush)         vld_n = '0;
    else if (alloc_we) vld_n[victim] = 1'b1;
  end

  assign resp_line  = (st_q == ST_WAIT) ? fill_data : src_line;
  assign resp_data  = pick_word(resp_line, req_addr[4:3], wide);
  assign resp_valid = req_valid && req_ready;
  assign line_addr  = mla_q;

  // registers with reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      mla_q    <= '0;
      malloc_q <= 1'b0;
      mnc_q    <= 1'b0;
      cur_v_q  <= 1'b0;
      pf_v_q   <= 1'b0;
      vld_q    <= '0;
    end else begin
      st_q     <= st_n;
      mla_q    <= mla_n;
      malloc_q <= malloc_n;
      mnc_q    <= mnc_n;
      cur_v_q  <= cur_v_n;
      pf_v_q   <= pf_v_n;
      vld_q    <= vld_n;
    end
  end

  // storage without reset, written under explicit enables
  always_ff @(posedge clk) begin
    if (cur_we) begin
      cur_la_q <= mla_q;
      cur_d_q  <= fill_data;
    end
    if (pf_load) begin
      pf_la_q <= pf_line;
      pf_d_q  <= pf_data;
    end
    if (alloc_we) begin
      tag_q[victim] <= mla_q;
      dat_q[victim] <= fill_data;
    end
  end

  fra_lru #(.LINES(LINES)) u_lru (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush      (flush),
    .touch_en   (touch_en),
    .touch_idx  (touch_idx),
    .oldest_idx (oldest_idx)
  );

  AST_LINE_UNIQUE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec)); // R4
  AST_CURBUF_NO_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && req_valid && cur_hit) |=> !line_req); // R5
  AST_STALL_UNTIL_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != ST_IDLE && !fill_valid) |-> !req_ready); // R11
  AST_NC_NOT_STORED: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_WAIT && fill_valid && mnc_q && !flush) |=> (vld_q == $past(vld_q))); // R7
  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (vld_q == '0 && !cur_v_q)); // R10
endmodule

// File: rtl/fra_arb.sv
module fra_arb #(
  parameter int LA_W = 15
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            i_line_req,
  input  logic [LA_W-1:0] i_line_addr,
  input  logic            d_line_req,
  input  logic [LA_W-1:0] d_line_addr,
  output logic            i_grant,
  output logic            d_grant,
  output logic            fl_req_valid,
  output logic [LA_W-1:0] fl_req_line,
  input  logic            fl_rsp_valid,
  output logic            i_fill_valid,
  output logic            d_fill_valid
);
  logic busy_q, busy_n;
  logic own_d_q, own_d_n;

  always_comb begin
    d_grant      = !busy_q && d_line_req;
    i_grant      = !busy_q && i_line_req && !d_line_req;
    fl_req_valid = d_grant || i_grant;
    fl_req_line  = d_grant ? d_line_addr : i_line_addr;
    busy_n       = busy_q;
    own_d_n      = own_d_q;
    if (fl_req_valid) begin
      busy_n  = 1'b1;
      own_d_n = d_grant;
    end else if (fl_rsp_valid) begin
      busy_n = 1'b0;
    end
  end

  assign d_fill_valid = fl_rsp_valid && busy_q && own_d_q;
  assign i_fill_valid = fl_rsp_valid && busy_q && !own_d_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      own_d_q <= 1'b0;
    end else begin
      busy_q  <= busy_n;
      own_d_q <= own_d_n;
    end
  end

  AST_DATA_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && d_line_req && i_line_req) |-> (fl_req_line == d_line_addr && !i_grant)); // R9
  AST_ONE_IN_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    fl_req_valid |=> !fl_req_valid); // R3
endmodule

// File: rtl/flash_read_accel.sv
module flash_read_accel
  import fra_pkg::*;
#(
  parameter int ADDR_W  = 20,
  parameter int I_LINES = 32,
  parameter int D_LINES = 8,
  parameter logic [NC_W-1:0] NC_TAG = 4'hF
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  mode_wide,
  input  logic                  i_en,
  input  logic                  d_en,
  input  logic                  flush,
  input  logic                  i_req_valid,
  input  logic [ADDR_W-1:0]     i_req_addr,
  output logic                  i_req_ready,
  output logic                  i_resp_valid,
  output logic [WORD_W-1:0]     i_resp_data,
  input  logic                  i_pf_load,
  input  logic [ADDR_W-6:0]     i_pf_line,
  input  logic [LINE_W-1:0]     i_pf_data,
  input  logic                  d_req_valid,
  input  logic [ADDR_W-1:0]     d_req_addr,
  input  logic                  d_req_dma,
  output logic                  d_req_ready,
  output logic                  d_resp_valid,
  output logic [WORD_W-1:0]     d_resp_data,
  output logic                  fl_req_valid,
  output logic [ADDR_W-6:0]     fl_req_line,
  input  logic                  fl_rsp_valid,
  input  logic [LINE_W-1:0]     fl_rsp_data
);
  localparam int LA_W = ADDR_W - OFS_W;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_core_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  logic            i_line_req, d_line_req, i_grant, d_grant;
  logic [LA_W-1:0] i_line_addr, d_line_addr;
  logic            i_fill_valid, d_fill_valid;

  fra_port #(.ADDR_W(ADDR_W), .LINES(I_LINES), .NC_TAG(NC_TAG)) u_iport (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .en         (i_en),
    .wide       (mode_wide),
    .flush      (flush),
    .req_valid  (i_req_valid),
    .req_addr   (i_req_addr),
    .req_dma    (1'b0),
    .req_ready  (i_req_ready),
    .resp_valid (i_resp_valid),
    .resp_data  (i_resp_data),
    .pf_load    (i_pf_load),
    .pf_line    (i_pf_line),
    .pf_data    (i_pf_data),
    .line_req   (i_line_req),
    .line_addr  (i_line_addr),
    .grant      (i_grant),
    .fill_valid (i_fill_valid),
    .fill_data  (fl_rsp_data)
  );

  fra_port #(.ADDR_W(ADDR_W), .LINES(D_LINES), .NC_TAG(NC_TAG)) u_dport (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .en         (d_en),
    .wide       (mode_wide),
    .flush      (flush),
    .req_valid  (d_req_valid),
    .req_addr   (d_req_addr),
    .req_dma    (d_req_dma),
    .req_ready  (d_req_ready),
    .resp_valid (d_resp_valid),
    .resp_data  (d_resp_data),
    .pf_load    (1'b0),
    .pf_line    ('0),
    .pf_data    ('0),
    .line_req   (d_line_req),
    .line_addr  (d_line_addr),
    .grant      (d_grant),
    .fill_valid (d_fill_valid),
    .fill_data  (fl_rsp_data)
  );

  fra_arb #(.LA_W(LA_W)) u_arb (
    .clk          (clk),
    .rst_n        (rst_core_n),
    .i_line_req   (i_line_req),
    .i_line_addr  (i_line_addr),
    .d_line_req   (d_line_req),
    .d_line_addr  (d_line_addr),
    .i_grant      (i_grant),
    .d_grant      (d_grant),
    .fl_req_valid (fl_req_valid),
    .fl_req_line  (fl_req_line),
    .fl_rsp_valid (fl_rsp_valid),
    .i_fill_valid (i_fill_valid),
    .d_fill_valid (d_fill_valid)
  );
endmodule

// File: tb/flash_read_accel_tb.sv
`timescale 1ns/1ps
module flash_read_accel_tb;
  localparam int ADDR_W = 20;
  localparam int LA_W   = ADDR_W - 5;
  localparam int LAT    = 3;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, mode_wide, i_en, d_en, flush;
  logic i_req_valid, i_req_ready, i_resp_valid;
  logic [ADDR_W-1:0] i_req_addr, d_req_addr;
  logic [127:0] i_resp_data, d_resp_data;
  logic i_pf_load;
  logic [LA_W-1:0] i_pf_line, fl_req_line;
  logic [255:0] i_pf_data, fl_rsp_data;
  logic d_req_valid, d_req_dma, d_req_ready, d_resp_valid;
  logic fl_req_valid, fl_rsp_valid;

  flash_read_accel u_dut (
    .clk(clk), .rst_n(rst_n), .mode_wide(mode_wide), .i_en(i_en), .d_en(d_en),
    .flush(flush), .i_req_valid(i_req_valid), .i_req_addr(i_req_addr),
    .i_req_ready(i_req_ready), .i_resp_valid(i_resp_valid), .i_resp_data(i_resp_data),
    .i_pf_load(i_pf_load), .i_pf_line(i_pf_line), .i_pf_data(i_pf_data),
    .d_req_valid(d_req_valid), .d_req_addr(d_req_addr), .d_req_dma(d_req_dma),
    .d_req_ready(d_req_ready), .d_resp_valid(d_resp_valid), .d_resp_data(d_resp_data),
    .fl_req_valid(fl_req_valid), .fl_req_line(fl_req_line),
    .fl_rsp_valid(fl_rsp_valid), .fl_rsp_data(fl_rsp_data)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string rq, input logic [255:0] act, input logic [255:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  function automatic logic [255:0] line_of(input int la);
    logic [255:0] l;
    for (int k = 0; k < 4; k++)
      l[k*64 +: 64] = {8'(8'hA0 + k), 8'h5C, 16'(la), 32'(la*13 + k + 1)};
    return l;
  endfunction

  function automatic logic [127:0] exp_word(input logic [ADDR_W-1:0] a, input logic w);
    logic [255:0] l;
    l = line_of(int'(a >> 5));
    if (w) return l[a[4]*128 +: 128];
    return {64'b0, l[a[4:3]*64 +: 64]};
  endfunction

  // flash model: fixed latency, one line in flight
  int fl_cnt = 0;
  int pcnt = 0;
  int pla = 0;
  int fl_log[$];
  always @(negedge clk) begin
    if (rst_n && fl_req_valid) begin
      fl_cnt++;
      fl_log.push_back(int'(fl_req_line));
      pla  = int'(fl_req_line);
      pcnt = LAT;
    end
  end
  always @(posedge clk) begin
    #1;
    fl_rsp_valid = 1'b0;
    if (pcnt > 0) begin
      pcnt--;
      if (pcnt == 0) begin
        fl_rsp_valid = 1'b1;
        fl_rsp_data  = line_of(pla);
      end
    end
  end

  // scoreboards
  logic [127:0] iq_d[$], dq_d[$];
  string iq_r[$], dq_r[$];
  always @(negedge clk) begin
    if (i_req_valid && i_req_ready) begin
      logic [127:0] e; string r;
      e = iq_d.pop_front(); r = iq_r.pop_front();
      chk(i_resp_valid && i_resp_data == e, r, {128'b0, i_resp_data}, {128'b0, e});
    end
    if (d_req_valid && d_req_ready) begin
      logic [127:0] e; string r;
      e = dq_d.pop_front(); r = dq_r.pop_front();
      chk(d_resp_valid && d_resp_data == e, r, {128'b0, d_resp_data}, {128'b0, e});
    end
  end

  // driver: exp_fetch = -1 skips the flash read count check
  task automatic rd(input bit dport, input logic [ADDR_W-1:0] a, input bit dma,
                    input int exp_fetch, input string rq);
    int f0, waits;
    @(posedge clk); #1;
    f0 = fl_cnt;
    if (dport) begin
      d_req_valid = 1'b1; d_req_addr = a; d_req_dma = dma;
      dq_d.push_back(exp_word(a, mode_wide)); dq_r.push_back(rq);
    end else begin
      i_req_valid = 1'b1; i_req_addr = a;
      iq_d.push_back(exp_word(a, mode_wide)); iq_r.push_back(rq);
    end
    waits = 0;
    @(negedge clk);
    while (!(dport ? d_req_ready : i_req_ready)) begin
      waits++;
      @(negedge clk);
    end
    @(posedge clk); #1;
    if (dport) d_req_valid = 1'b0; else i_req_valid = 1'b0;
    if (exp_fetch >= 0) begin
      chk(fl_cnt - f0 == exp_fetch, {rq, " flash reads"}, 256'(fl_cnt - f0), 256'(exp_fetch));
      if (exp_fetch == 0) chk(waits == 0, {rq, " zero-wait"}, 256'(waits), 256'(0));
      else                chk(waits > 0, "R11 stall on miss", 256'(waits), 256'(1));
    end
  endtask

  task automatic pulse_flush();
    @(posedge clk); #1 flush = 1'b1;
    @(posedge clk); #1 flush = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL R11 watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int base;
    rst_n = 1'b0; mode_wide = 1'b0; i_en = 1'b1; d_en = 1'b1; flush = 1'b0;
    i_req_valid = 1'b0; i_req_addr = '0; i_pf_load = 1'b0; i_pf_line = '0; i_pf_data = '0;
    d_req_valid = 1'b0; d_req_addr = '0; d_req_dma = 1'b0;
    fl_rsp_valid = 1'b0; fl_rsp_data = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(!fl_req_valid && !i_resp_valid && !d_resp_valid, "R3 reset idle",
        256'({fl_req_valid, i_resp_valid, d_resp_valid}), 256'(0));

    // R1/R3: miss, then current buffer, array hit, wide word
    rd(0, 20'h00100, 0, 1, "R3 first miss");
    rd(0, 20'h00108, 0, 0, "R5 current buffer");
    rd(0, 20'h00200, 0, 1, "R3 second miss");
    rd(0, 20'h00110, 0, 0, "R2 array hit");
    mode_wide = 1'b1;
    rd(0, 20'h00118, 0, 0, "R1 wide word");
    rd(0, 20'h00200, 0, 0, "R1 wide word low");
    mode_wide = 1'b0;
    rd(0, 20'h00218, 0, 0, "R1 narrow word 3");

    // R12: prefetch buffer
    @(posedge clk); #1 i_pf_load = 1'b1; i_pf_line = 15'd40; i_pf_data = line_of(40);
    @(posedge clk); #1 i_pf_load = 1'b0;
    rd(0, 20'h00508, 0, 0, "R12 prefetch hit");

    // R7: non-cacheable region re-fetched every time
    rd(0, 20'hF0020, 0, 1, "R7 nc first");
    rd(0, 20'hF0028, 0, 1, "R7 nc repeat");

    // R6: disabled array neither searched nor filled
    i_en = 1'b0;
    rd(0, 20'h00300, 0, 1, "R6 off miss A");
    rd(0, 20'h00400, 0, 1, "R6 off miss B");
    rd(0, 20'h00300, 0, 1, "R6 off A not kept");
    rd(0, 20'h00110, 0, 1, "R6 off no lookup");
    rd(0, 20'h00118, 0, 0, "R6 buffer still serves");
    i_en = 1'b1;

    // R10: flush
    rd(0, 20'h00200, 0, 0, "R10 before flush");
    pulse_flush();
    rd(0, 20'h00200, 0, 1, "R10 array cleared");
    rd(0, 20'h00508, 0, 1, "R10 prefetch cleared");

    // R4: free-first then LRU on the 8-entry data cache
    base = 'h1000;
    for (int k = 0; k < 8; k++) rd(1, 20'(base + 32*k), 0, 1, "R4 fill free");
    rd(1, 20'(base + 0),   0, 0, "R4 touch L0");
    rd(1, 20'(base + 256), 0, 1, "R4 new L8");
    rd(1, 20'(base + 32),  0, 1, "R4 L1 evicted");
    rd(1, 20'(base + 0),   0, 0, "R4 L0 kept");
    rd(1, 20'(base + 64),  0, 1, "R4 L2 evicted");
    rd(1, 20'(base + 224), 0, 0, "R4 L7 kept");
    rd(1, 20'(base + 96),  0, 1, "R4 L3 evicted");

    // R8: DMA bypasses the data cache array
    rd(1, 20'h02000, 1, 1, "R8 dma miss");
    rd(1, 20'h02400, 0, 1, "R8 cpu miss");
    rd(1, 20'h02000, 0, 1, "R8 dma line not kept");
    rd(1, 20'h02400, 0, 0, "R8 cpu line kept");
    rd(1, 20'(base + 224), 1, 1, "R8 dma no lookup");

    // R9: simultaneous misses, data port first
    base = fl_log.size();
    fork
      rd(0, 20'h00600, 0, -1, "R9 instr data");
      rd(1, 20'h03000, 0, -1, "R9 data data");
    join
    chk(fl_log.size() == base + 2 && fl_log[base] == ('h03000 >> 5), "R9 order first",
        256'(fl_log[base]), 256'('h03000 >> 5));
    chk(fl_log[base+1] == ('h00600 >> 5), "R9 order second",
        256'(fl_log[base+1]), 256'('h00600 >> 5));

    repeat (5) @(posedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule